// File: doc/BRIEF.md
# Two-Region Page Address Translator

This block sits between an I/O bus whose addresses have been widened to 32 bits and a wide system bus. Each access on the I/O side presents an address and a strobe. The block turns that address into a system address through one of two independent page tables, and the address range picks which table is used.

Addresses below 1 MB go through a 64 KB window whose base can be programmed. Inside that window the address is remapped in 4 KB pages, using a 16-entry table. Addresses from 1 MB up to 15 MB are remapped in 1 MB pages, using a 14-entry table. Every other address is a miss.

One cycle after a strobe the block reports either a hit together with the translated address, or a miss. A single write port loads the table entries and the window base.

The region decode is a pure classifier that drives a small enumerated result: none, low or high. The lookup is combinational. The result is captured once in an output register.

Top module: `page_xlate_top`

## Requirements
- R1: An address is classified by its bits [31:20]. A value of 0 selects the low region. Values 1 to 14 select the high region. Any value of 15 or above (an address at or above 15 MB) always gives a miss.
- R2: A low-region address is inside the window only when its bits [19:16] equal the 4-bit window base. A low-region address outside the window gives a miss.
- R3: A low-window hit uses low entry number addr[15:12]. It returns {entry page (20 bits), addr[11:0]}.
- R4: A high-region hit uses high entry number addr[23:20]-1. It returns {entry page (12 bits), addr[19:0]}.
- R5: A lookup that selects an entry whose valid bit is clear gives a miss. Every miss drives out_addr to zero.
- R6: A strobe in cycle N produces its result in cycle N+1, with exactly one of out_hit and out_miss high. In any cycle after a cycle with no strobe, out_hit, out_miss and out_addr are all zero.
- R7: Write encoding. cfg_idx 0 to 15 writes low entry cfg_idx. cfg_idx 16 to 29 writes high entry cfg_idx-16. cfg_idx 31 writes the window base from cfg_wdata[3:0]. For entry writes, cfg_wdata[20] is the valid bit and cfg_wdata[19:0] is the page: a low entry uses all 20 bits and a high entry uses bits [11:0]. A write with cfg_idx 30 changes nothing.
- R8: A write takes effect in the cycle after it is made. A lookup strobed in the same cycle as a write sees the contents from before the write.
- R9: After reset every entry is invalid, the window base is zero, and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 32 | I/O-side bus address |
| cfg_we | input | 1 | Table write enable |
| cfg_idx | input | 5 | Entry or base select |
| cfg_wdata | input | 21 | Valid bit and page field, or base |
| out_hit | output | 1 | Registered translation hit |
| out_miss | output | 1 | Registered translation miss |
| out_addr | output | 32 | Registered translated system address |

## Verification
A table write and a lookup can land in the same cycle, and a lookup can even target the very entry being written. The bench provokes this by strobing an address while it changes the valid bit or the page of that address's entry, or while it moves the window base onto or off that address. The lookup result is judged against the table model as it stood before the write. The following strobe to the same address is then judged against the updated model.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;
    localparam int ADDR_W      = 32;
    localparam int LOW_PG_SH   = 12;
    localparam int WIN_SH      = 16;
    localparam int HIGH_PG_SH  = 20;
    localparam int HIGH_N      = 14;
    localparam int LOW_N       = 1 << (WIN_SH - LOW_PG_SH);
    localparam int LOW_IDX_W   = WIN_SH - LOW_PG_SH;
    localparam int HIGH_IDX_W  = $clog2(HIGH_N);
    localparam int WIN_W       = HIGH_PG_SH - WIN_SH;
    localparam int LOW_TAG_W   = ADDR_W - LOW_PG_SH;
    localparam int HIGH_TAG_W  = ADDR_W - HIGH_PG_SH;
    localparam int MB_W        = ADDR_W - HIGH_PG_SH;
    localparam int CFG_IDX_W   = 5;
    localparam int CFG_W       = LOW_TAG_W + 1;
    localparam int CFG_HIGH_BASE = 16;
    localparam int CFG_WIN_IDX   = 31;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_LOW  = 2'd1,
        RGN_HIGH = 2'd2
    } rgn_e;
endpackage

// File: rtl/page_xlate_table.sv
module page_xlate_table #(
    parameter int N     = 16,
    parameter int TAG_W = 20,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_vld,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_vld,
    output logic [TAG_W-1:0] rd_tag
);
    logic [N-1:0]     vld_q;
    logic [TAG_W-1:0] tag_q [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[i] <= 1'b0;
                tag_q[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                vld_q[i] <= wr_vld;
                tag_q[i] <= wr_tag;
            end
        end
    end

    always_comb begin
        rd_vld = 1'b0;
        rd_tag = '0;
        for (int i = 0; i < N; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_vld = vld_q[i];
                rd_tag = tag_q[i];
            end
        end
    end
endmodule

// File: rtl/page_xlate_decode.sv
module page_xlate_decode
    import page_xlate_pkg::*;
(
    input  logic [ADDR_W-1:0]     addr,
    input  logic [WIN_W-1:0]      win_base,
    output rgn_e                  rgn,
    output logic [LOW_IDX_W-1:0]  low_idx,
    output logic [HIGH_IDX_W-1:0] high_idx
);
    logic [MB_W-1:0] mb;

    assign mb       = addr[ADDR_W-1:HIGH_PG_SH];
    assign low_idx  = addr[WIN_SH-1:LOW_PG_SH];
    assign high_idx = addr[HIGH_PG_SH+HIGH_IDX_W-1:HIGH_PG_SH] - HIGH_IDX_W'(1);

    always_comb begin
        if (mb == '0) begin
            rgn = (addr[HIGH_PG_SH-1:WIN_SH] == win_base) ? RGN_LOW : RGN_NONE;
        end else if (mb <= MB_W'(HIGH_N)) begin
            rgn = RGN_HIGH;
        end else begin
            rgn = RGN_NONE;
        end
    end
endmodule

// File: rtl/page_xlate_top.sv
module page_xlate_top
    import page_xlate_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic                 cfg_we,
    input  logic [CFG_IDX_W-1:0] cfg_idx,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic                 out_hit,
    output logic                 out_miss,
    output logic [ADDR_W-1:0]    out_addr
);
    logic [WIN_W-1:0]      win_q;
    rgn_e                  rgn;
    logic [LOW_IDX_W-1:0]  low_idx;
    logic [HIGH_IDX_W-1:0] high_idx;
    logic                  low_vld, high_vld;
    logic [LOW_TAG_W-1:0]  low_tag;
    logic [HIGH_TAG_W-1:0] high_tag;
    logic                  wr_low, wr_high, wr_win;
    logic [HIGH_IDX_W-1:0] wr_high_idx;
    logic                  hit_c;
    logic [ADDR_W-1:0]     xl_c;

    // write-port decode
    assign wr_low      = cfg_we && (cfg_idx < CFG_IDX_W'(LOW_N));
    assign wr_high_idx = HIGH_IDX_W'(cfg_idx - CFG_IDX_W'(CFG_HIGH_BASE));
    assign wr_high     = cfg_we && (cfg_idx >= CFG_IDX_W'(CFG_HIGH_BASE))
                                && (cfg_idx <  CFG_IDX_W'(CFG_HIGH_BASE + HIGH_N));
    assign wr_win      = cfg_we && (cfg_idx == CFG_IDX_W'(CFG_WIN_IDX));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (wr_win) begin
            win_q <= cfg_wdata[WIN_W-1:0];
        end
    end

    page_xlate_decode dec_i (
        .addr     (acc_addr),
        .win_base (win_q),
        .rgn      (rgn),
        .low_idx  (low_idx),
        .high_idx (high_idx)
    );

    page_xlate_table #(.N(LOW_N), .TAG_W(LOW_TAG_W), .IDX_W(LOW_IDX_W)) low_tbl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_low),
        .wr_idx (cfg_idx[LOW_IDX_W-1:0]),
        .wr_vld (cfg_wdata[CFG_W-1]),
        .wr_tag (cfg_wdata[LOW_TAG_W-1:0]),
        .rd_idx (low_idx),
        .rd_vld (low_vld),
        .rd_tag (low_tag)
    );

    page_xlate_table #(.N(HIGH_N), .TAG_W(HIGH_TAG_W), .IDX_W(HIGH_IDX_W)) high_tbl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_high),
        .wr_idx (wr_high_idx),
        .wr_vld (cfg_wdata[CFG_W-1]),
        .wr_tag (cfg_wdata[HIGH_TAG_W-1:0]),
        .rd_idx (high_idx),
        .rd_vld (high_vld),
        .rd_tag (high_tag)
    );

    // combinational translation
    always_comb begin
        hit_c = 1'b0;
        xl_c  = '0;
        unique case (rgn)
            RGN_LOW: begin
                hit_c = low_vld;
                xl_c  = {low_tag, acc_addr[LOW_PG_SH-1:0]};
            end
            RGN_HIGH: begin
                hit_c = high_vld;
                xl_c  = {high_tag, acc_addr[HIGH_PG_SH-1:0]};
            end
            default: begin
                hit_c = 1'b0;
                xl_c  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_hit  <= 1'b0;
            out_miss <= 1'b0;
            out_addr <= '0;
        end else begin
            out_hit  <= acc_valid && hit_c;
            out_miss <= acc_valid && !hit_c;
            out_addr <= (acc_valid && hit_c) ? xl_c : '0;
        end
    end
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic [31:0] acc_addr,
    input logic        out_hit,
    input logic        out_miss,
    input logic [31:0] out_addr
);
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (out_hit ^ out_miss)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!out_hit && !out_miss && out_addr == 32'h0)); // R6
    AST_TOP_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr[31:20] >= 12'd15) |=> out_miss); // R1
    AST_LOW_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr[31:20] == 12'd0) |=>
        (out_miss || out_addr[11:0] == $past(acc_addr[11:0]))); // R3
    AST_HIGH_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr[31:20] != 12'd0 && acc_addr[31:20] < 12'd15) |=>
        (out_miss || out_addr[19:0] == $past(acc_addr[19:0]))); // R4
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_miss |-> out_addr == 32'h0); // R5
endmodule

bind page_xlate_top page_xlate_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .out_hit   (out_hit),
    .out_miss  (out_miss),
    .out_addr  (out_addr)
);

// File: tb/page_xlate_tb.sv
module page_xlate_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_idx = '0;
    logic [20:0] cfg_wdata = '0;
    logic        out_hit, out_miss;
    logic [31:0] out_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model
    bit          m_lv [16];
    logic [19:0] m_lp [16];
    bit          m_hv [14];
    logic [11:0] m_hp [14];
    logic [3:0]  m_base;

    always #5 clk = ~clk;

    page_xlate_top dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .out_hit(out_hit), .out_miss(out_miss), .out_addr(out_addr)
    );

    task automatic chk(input string req, input bit ok, input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void predict(input logic [31:0] a, output bit h, output logic [31:0] x,
                                    output string req);
        int p, k;
        h = 0; x = 0;
        if (a < 32'h0010_0000) begin
            p = int'((a >> 12) % 16);
            if (((a >> 16) % 16) != m_base) req = "R2";
            else if (!m_lv[p]) req = "R5";
            else begin
                h = 1; req = "R3";
                x = m_lp[p] * 32'd4096 + (a % 4096);
            end
        end else if (a < 32'h00F0_0000) begin
            k = int'(a / 32'h0010_0000) - 1;
            if (!m_hv[k]) req = "R5";
            else begin
                h = 1; req = "R4";
                x = m_hp[k] * 32'h0010_0000 + (a % 32'h0010_0000);
            end
        end else req = "R1";
    endfunction

    function automatic void model_write(input int idx, input logic [20:0] d);
        if (idx < 16) begin m_lv[idx] = d[20]; m_lp[idx] = d[19:0]; end
        else if (idx < 30) begin m_hv[idx-16] = d[20]; m_hp[idx-16] = d[11:0]; end
        else if (idx == 31) m_base = d[3:0];
    endfunction

    task automatic cfg_write(input int idx, input logic [20:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        model_write(idx, d);   // R7
    endtask

    task automatic lookup(input logic [31:0] a);
        bit h; logic [31:0] x; string req;
        predict(a, h, x, req);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0;
        chk(req, {out_hit, out_miss, out_addr} == {h, !h, x},
            {out_hit, out_miss, out_addr}, {h, !h, x});
        @(negedge clk);
        chk("R6", {out_hit, out_miss, out_addr} == 34'h0, {out_hit, out_miss, out_addr}, 34'h0);
    endtask

    // write and lookup in one cycle: R8
    task automatic write_and_look(input int idx, input logic [20:0] d, input logic [31:0] a);
        bit h; logic [31:0] x; string req;
        predict(a, h, x, req);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_wdata = d;
        acc_valid = 1'b1; acc_addr = a;
        @(negedge clk);
        cfg_we = 1'b0; acc_valid = 1'b0;
        chk("R8", {out_hit, out_miss, out_addr} == {h, !h, x},
            {out_hit, out_miss, out_addr}, {h, !h, x});
        model_write(idx, d);
        lookup(a);
    endtask

    task automatic sweep();
        for (int b = 0; b < 16; b++)
            for (int p = 0; p < 16; p++)
                lookup((32'(b) << 16) | (32'(p) << 12) | 32'((b * 37 + p * 91) % 4096));
        for (int m = 0; m < 32; m++)
            lookup((32'(m) << 20) | ((32'(m) * 32'h1234) % 32'h0010_0000));
        lookup(32'hFFFF_FFFF);
        lookup(32'h8000_0000);
        lookup(32'h00EF_FFFF);
        lookup(32'h00F0_0000);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin m_lv[i] = 0; m_lp[i] = 0; end
        for (int i = 0; i < 14; i++) begin m_hv[i] = 0; m_hp[i] = 0; end
        m_base = 0;
        repeat (3) @(negedge clk);
        chk("R9", {out_hit, out_miss, out_addr} == 34'h0, {out_hit, out_miss, out_addr}, 34'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", {out_hit, out_miss, out_addr} == 34'h0, {out_hit, out_miss, out_addr}, 34'h0);
        // R9: all entries invalid after reset
        sweep();
        // R7: fill both tables and move the window
        for (int p = 0; p < 16; p++) cfg_write(p, {1'b1, 20'hA0000 + 20'(p * 32'h111)});
        for (int k = 0; k < 14; k++) cfg_write(16 + k, {1'b1, 8'h5A, 12'h800 + 12'(k * 3)});
        cfg_write(31, 21'h1FFF05);
        sweep();
        // R5: invalidate odd entries
        for (int i = 1; i < 30; i += 2) cfg_write(i, 21'h0ABCDE);
        sweep();
        // R7: index 30 is ignored
        cfg_write(30, 21'h1FFFFF);
        sweep();
        // R8: same-cycle collisions
        write_and_look(2, {1'b0, 20'h12345}, 32'h0005_2ABC);
        write_and_look(2, {1'b1, 20'h54321}, 32'h0005_2ABC);
        write_and_look(16, {1'b0, 20'h00777}, 32'h0012_3456);
        write_and_look(16, {1'b1, 20'h00777}, 32'h0012_3456);
        write_and_look(31, 21'h000009, 32'h0009_4010);
        write_and_look(31, 21'h000005, 32'h0009_4010);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule